// File: doc/BRIEF.md
# Delay-Lock Readiness and Latency-Mode Sequencer

This block decides when the delay-lock function of a synchronous memory may be trusted. It also picks the read-latency mode that the read path uses. It does the counting and sequencing only: the analog delay line and the output-driver calibration are elsewhere. The block runs on a free-running reference clock. It samples the memory's input clock as data, so it can see that input clock stop as well as run.

Each rising edge of the input clock is one input cycle. While the enable pin is high, the lock flag rises after an unbroken run of `LOCK_CYCLES` input cycles. A gap between input-clock edges that exceeds the stop threshold clears the lock and restarts the run; the threshold is 30 ns, converted to reference ticks. No reset is needed to reach lock, because a steady clock is enough. With the enable pin low, the lock function is off and the latency-mode output selects the reduced one-cycle mode. A separate counter issues a one-cycle impedance-update request every `ZQ_CYCLES` input cycles, and a clock stop restarts that counter.

Top module: `dlock_seq`

## Requirements
- R1: With `dllEn` high, `lockOut` stays low until the 1024th input-clock rising edge after a restart. It is high in the 3rd reference cycle after that edge is driven, and not before.
- R2: A gap of more than `STOP_TICKS` (3) reference cycles between input rising edges drops `lockOut` 3 + `STOP_TICKS` cycles after the last edge. The next edge then counts as edge 1 of a new 1024-edge run.
- R3: Rising edges spaced exactly `STOP_TICKS` reference cycles apart are not a stop: lock and counts are undisturbed.
- R4: While `dllEn` is held low, `lockOut` is 0 and `latMode` is 1 (reduced, one-cycle latency), whatever the input clock does.
- R5: `latMode` is 0 (full latency) when enabled and 1 (reduced) when disabled. It changes only in a cycle where `lockOut` was already low. After `dllEn` falls, `lockOut` drops 3 cycles later and `latMode` rises one cycle after that.
- R6: `zqReq` is a single-cycle pulse, 3 reference cycles after every 1024th input rising edge. It is independent of `dllEn`.
- R7: A clock stop restarts the impedance-update count, so the first pulse after a restart coincides with the relock cycle.
- R8: During reset, `lockOut` = 0, `latMode` = 1 and `zqReq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock (10 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| inClk | input | 1 | Monitored input clock, sampled as data |
| dllEn | input | 1 | Delay-lock enable pin (high = enabled) |
| lockOut | output | 1 | Lock-ready flag |
| latMode | output | 1 | Read-latency select: 0 full, 1 reduced |
| zqReq | output | 1 | One-cycle impedance-update request |

## Verification
Every result lags its cause by a fixed number of reference cycles. A driven input-clock edge takes two synchronizer stages and one state register, so lock and update pulses appear in the 3rd cycle after the edge. A stop shows as lock low `STOP_TICKS` + 3 cycles after the last edge. An enable fall shows as lock low after 3 cycles and a latency-mode change after 4. The bench drives on falling reference edges and keeps a per-cycle arithmetic model of edge counts and gap lengths. At each falling edge it predicts lock and pulse outputs from that model and compares them, so lock is checked at exactly 1024 edges, across relock and at every pulse spacing.

// File: rtl/dlock_pkg.sv
package dlock_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_COUNT,
    ST_LOCKED
  } lockState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrStable;
    logic cntEn;
  } seqCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic edgeSeen;
    logic stopEv;
    logic countFull;
    logic enOk;
  } seqStat_t;

endpackage

// File: rtl/dlock_dp.sv
module dlock_dp
  import dlock_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int ZQ_CYCLES   = 1024,
  parameter int STOP_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inClk,
  input  logic     dllEn,
  input  seqCmd_t  cmd,
  output seqStat_t stat,
  output logic     zqReq
);

  localparam int SW = $clog2(LOCK_CYCLES);
  localparam int ZW = $clog2(ZQ_CYCLES);
  localparam int GW = $clog2(STOP_TICKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(LOCK_CYCLES - 1);
  localparam logic [ZW-1:0] Z_LAST = ZW'(ZQ_CYCLES - 1);
  localparam logic [GW-1:0] G_LAST = GW'(STOP_TICKS - 1);
  localparam logic [GW-1:0] G_MAX  = GW'(STOP_TICKS);

  // synchronizers: clkPipe carries one extra history stage for edge detect
  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] enPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPipe[0] <= 1'b0;
      enPipe[0]  <= 1'b0;
    end else begin
      clkPipe[0] <= inClk;
      enPipe[0]  <= dllEn;
    end
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_clkSync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clkPipe[i] <= 1'b0;
      else        clkPipe[i] <= clkPipe[i-1];
    end
  end

  for (genvar j = 1; j < SYNC_STAGES; j++) begin : g_enSync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) enPipe[j] <= 1'b0;
      else        enPipe[j] <= enPipe[j-1];
    end
  end

  logic edgeSeen;
  assign edgeSeen = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];

  // gap timer: reference ticks since the last seen edge, saturating
  logic [GW-1:0] gapCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gapCnt <= '0;
    else if (edgeSeen)         gapCnt <= '0;
    else if (gapCnt != G_MAX)  gapCnt <= gapCnt + 1'b1;
  end

  logic stopEv;
  assign stopEv = !edgeSeen && (gapCnt == G_LAST);

  // stable-run counter
  logic [SW-1:0] stableCnt;
  logic          countFull;
  assign countFull = (stableCnt == S_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     stableCnt <= '0;
    else if (cmd.clrStable)                         stableCnt <= '0;
    else if (cmd.cntEn && edgeSeen && !countFull)   stableCnt <= stableCnt + 1'b1;
  end

  // impedance-update period counter
  logic [ZW-1:0] zqCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zqCnt <= '0;
      zqReq <= 1'b0;
    end else begin
      zqReq <= edgeSeen && (zqCnt == Z_LAST);
      if (stopEv)        zqCnt <= '0;
      else if (edgeSeen) zqCnt <= (zqCnt == Z_LAST) ? '0 : zqCnt + 1'b1;
    end
  end

  assign stat.edgeSeen  = edgeSeen;
  assign stat.stopEv    = stopEv;
  assign stat.countFull = countFull;
  assign stat.enOk      = enPipe[SYNC_STAGES-1];

endmodule

// File: rtl/dlock_ctrl.sv
module dlock_ctrl
  import dlock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     lockOut,
  output logic     latMode
);

  lockState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (!stat.enOk)       stateNxt = ST_OFF;
    else if (stat.stopEv) stateNxt = ST_COUNT;
    else begin
      case (state)
        ST_OFF:   stateNxt = ST_COUNT;
        ST_COUNT: if (stat.edgeSeen && stat.countFull) stateNxt = ST_LOCKED;
        default:  stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= stateNxt;
  end

  // latency select moves only while not locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  latMode <= 1'b1;
    else if (state != ST_LOCKED) latMode <= !stat.enOk;
  end

  assign cmd.clrStable = (state == ST_OFF) || stat.stopEv || !stat.enOk;
  assign cmd.cntEn     = (state == ST_COUNT);
  assign lockOut       = (state == ST_LOCKED);

endmodule

// File: rtl/dlock_seq.sv
module dlock_seq
  import dlock_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int ZQ_CYCLES   = 1024,
  parameter int STOP_NS     = 30,
  parameter int REF_PS      = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rst_n,
  input  logic inClk,
  input  logic dllEn,
  output logic lockOut,
  output logic latMode,
  output logic zqReq
);

  localparam int STOP_TICKS = (STOP_NS * 1000 + REF_PS - 1) / REF_PS;

  seqCmd_t  cmd;
  seqStat_t stat;

  dlock_dp #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .ZQ_CYCLES   (ZQ_CYCLES),
    .STOP_TICKS  (STOP_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk   (refClk),
    .rst_n (rst_n),
    .inClk (inClk),
    .dllEn (dllEn),
    .cmd   (cmd),
    .stat  (stat),
    .zqReq (zqReq)
  );

  dlock_ctrl u_ctrl (
    .clk     (refClk),
    .rst_n   (rst_n),
    .stat    (stat),
    .cmd     (cmd),
    .lockOut (lockOut),
    .latMode (latMode)
  );

endmodule

// File: rtl/dlock_chk.sv
module dlock_chk (
  input logic clk,
  input logic rst_n,
  input logic dllEn,
  input logic lockOut,
  input logic latMode,
  input logic zqReq,
  input logic edgeSeen,
  input logic stopEv
);

  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
  end

  // R1: lock only rises right after a counted input edge
  a_r1_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd1 && $rose(lockOut)) |-> $past(edgeSeen));

  // R2: a detected stop removes lock on the next cycle
  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stopEv |=> !lockOut);

  // R4: enable held low for five samples -> unlocked and reduced mode
  a_r4_disabled_state: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd5 && !dllEn && !$past(dllEn) && !$past(dllEn, 2)
     && !$past(dllEn, 3) && !$past(dllEn, 4)) |-> (!lockOut && latMode));

  // R5: latency select changes only when lock was low
  a_r5_mode_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd1 && !$stable(latMode)) |-> !$past(lockOut));

  // R6: update request lasts a single cycle
  a_r6_zq_single: assert property (@(posedge clk) disable iff (!rst_n)
    zqReq |=> !zqReq);

endmodule

bind dlock_seq dlock_chk u_chk (
  .clk      (refClk),
  .rst_n    (rst_n),
  .dllEn    (dllEn),
  .lockOut  (lockOut),
  .latMode  (latMode),
  .zqReq    (zqReq),
  .edgeSeen (stat.edgeSeen),
  .stopEv   (stat.stopEv)
);

// File: tb/sim_dlock_seq.sv
`timescale 1ns/1ps
module sim_dlock_seq;

  localparam int LOCK_N = 1024;
  localparam int ZQ_N   = 1024;
  localparam int STOP_N = 3;
  localparam int BIG    = 32'h3fff_ffff;

  logic refClk = 1'b0;
  logic rst_n  = 1'b0;
  logic inClk  = 1'b0;
  logic dllEn  = 1'b1;
  logic lockOut, latMode, zqReq;

  always #5 refClk = ~refClk;

  dlock_seq #(
    .LOCK_CYCLES (LOCK_N),
    .ZQ_CYCLES   (ZQ_N),
    .STOP_NS     (30),
    .REF_PS      (10000),
    .SYNC_STAGES (2)
  ) u0 (
    .refClk  (refClk),
    .rst_n   (rst_n),
    .inClk   (inClk),
    .dllEn   (dllEn),
    .lockOut (lockOut),
    .latMode (latMode),
    .zqReq   (zqReq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // arithmetic model state
  int cyc = 0;
  int lastRise = -1000;
  int lockRises = 0, zqRises = 0;
  int lockAt = BIG, dropAt = 0, oldAt = BIG, oldDrop = 0;
  int zqAt = -1;
  int zqSeen = 0, zqLastCyc = -1, lockRiseCyc = -1;
  bit prevLock = 0;
  bit lockChk = 0, zqChk = 0, disChk = 0;
  bit sLock, sMode, sZq;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit expLock(int c);
    return (c >= lockAt && c < dropAt) || (c >= oldAt && c < oldDrop);
  endfunction

  // one reference cycle: sample at falling edge, then drive inClk
  task automatic tick(bit v);
    @(negedge refClk);
    cyc++;
    sLock = lockOut; sMode = latMode; sZq = zqReq;
    if (sZq) begin zqSeen++; zqLastCyc = cyc; end
    if (sLock && !prevLock) lockRiseCyc = cyc;
    prevLock = sLock;
    if (lockChk) check(sLock == expLock(cyc), "R1 R2 R3 lock", int'(sLock), int'(expLock(cyc)));
    if (zqChk)   check(sZq == (cyc == zqAt), "R6 zq", int'(sZq), int'(cyc == zqAt));
    if (disChk)  check(!sLock && sMode, "R4 disabled", {sLock, sMode}, 1);
    if (v && !inClk) begin
      if (cyc - lastRise > STOP_N) begin
        oldAt = lockAt; oldDrop = dropAt;
        lockAt = BIG; lockRises = 1; zqRises = 1;
      end else begin
        lockRises++; zqRises++;
      end
      lastRise = cyc;
      dropAt = cyc + STOP_N + 3;
      if (lockRises == LOCK_N) lockAt = cyc + 3;
      if (zqRises % ZQ_N == 0) zqAt = cyc + 3;
    end
    inClk = v;
  endtask

  task automatic gapPulse(int g);
    tick(1'b1);
    for (int k = 1; k < g; k++) tick(1'b0);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) gapPulse(2);
  endtask

  task automatic hold(int n);
    for (int k = 0; k < n; k++) tick(1'b0);
  endtask

  initial begin
    // R8: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge refClk);
      check(!lockOut && latMode && !zqReq, "R8 reset", {lockOut, latMode, zqReq}, 3'b010);
    end
    rst_n = 1'b1;
    zqChk = 1;
    hold(8);
    check(latMode == 1'b0, "R5 full mode when enabled", latMode, 0);
    lockChk = 1;

    // R1: first lock from power-up, exact count
    run(LOCK_N - 1);
    check(lockOut == 1'b0, "R1 before 1024th edge", lockOut, 0);
    run(2);
    check(lockOut == 1'b1, "R1 locked", lockOut, 1);
    check(zqSeen == 1, "R6 first pulse", zqSeen, 1);

    // R6: spacing to the second pulse
    run(1100);
    check(zqSeen == 2, "R6 second pulse", zqSeen, 2);

    // R3: gaps of exactly STOP_N ticks keep lock
    for (int k = 0; k < 5; k++) gapPulse(STOP_N);
    run(50);
    check(lockOut == 1'b1, "R3 gap at threshold", lockOut, 1);

    // R2: gap of STOP_N+1 drops lock and restarts the run
    gapPulse(STOP_N + 1);
    run(10);
    check(lockOut == 1'b0, "R2 dropped after gap", lockOut, 0);
    run(LOCK_N);
    check(lockOut == 1'b1, "R2 relock", lockOut, 1);
    check(lockRiseCyc == zqLastCyc, "R7 pulse with relock", zqLastCyc, lockRiseCyc);

    // R2: long stop
    hold(20);
    check(lockOut == 1'b0, "R2 long stop", lockOut, 0);
    run(LOCK_N + 5);
    check(lockOut == 1'b1, "R2 relock after long stop", lockOut, 1);
    check(lockRiseCyc == zqLastCyc, "R7 pulse with relock", zqLastCyc, lockRiseCyc);

    // R5: enable fall ordering
    lockChk = 0;
    dllEn = 1'b0;
    tick(1'b1);
    tick(1'b0);
    check(sLock == 1'b1, "R5 lock still high at +2", sLock, 1);
    tick(1'b1);
    check(sLock == 1'b0 && sMode == 1'b0, "R5 lock low, mode held at +3", {sLock, sMode}, 0);
    tick(1'b0);
    check(sMode == 1'b1, "R5 reduced mode at +4", sMode, 1);

    // R4: disabled with clock running
    disChk = 1;
    run(1500);
    disChk = 0;
    check(!lockOut && latMode, "R4 disabled end", {lockOut, latMode}, 1);

    // re-enable with clock stopped, then relock
    hold(10);
    dllEn = 1'b1;
    hold(10);
    check(latMode == 1'b0, "R5 full mode after enable", latMode, 0);
    lockChk = 1;
    run(LOCK_N + 5);
    check(lockOut == 1'b1, "R1 lock after re-enable", lockOut, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge refClk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule